// File: doc/BRIEF.md
# PLA Self-Test Pattern Sequencer

This block produces the full deterministic stimulus for a self-testable programmable logic array with L inputs, M product terms and N outputs. A row ring drives the bit lines of the AND plane, or the rows of the OR plane, with a single marked cell. A column ring selects one product term at a time by driving it low. Three active-low plane-select lines tell the array which rows are under test. Each ring has one cell more than the lines it drives. That spare cell gives one all-background row pattern and one all-ones column pattern per wrap.

A single test-initialize pin runs the whole test. After master reset, raising the pin loads the first phase. The row ring then turns once per clock. The column ring steps only on the clock in which the row ring leaves its last active cell. A two-bit phase counter moves on when the column ring completes its last position. There are three phases. Phase one checks the true bit lines with a walking one. Phase two checks the complemented bit lines with a walking zero. Phase three checks the OR-plane rows with a walking zero over N+1 cells. When phase three finishes, a done flag rises and every output holds its value until the next reset.

The master reset is asynchronous and active low. Its release passes through a two-flop synchronizer, so the block leaves reset on the second rising clock edge after the pin goes high.

Top module: `pla_test_seq`

## Requirements
- R1: While reset is active, and after reset with test_init low, the row and column patterns are all zero, done is 0, and the select lines read sel_true_n=0, sel_comp_n=0, sel_or_n=1. The block stays idle until test_init is high.
- R2: On the first clock with test_init high after reset, the block enters phase one. The row pattern becomes a one in cell 0 with all other cells 0. The column pattern becomes a zero in cell 0 with all other cells 1.
- R3: In phase one the row ring rotates one cell toward higher indices on every clock, over cells 0..L. Cell L wraps back to cell 0. Cells above L hold 0.
- R4: The column ring has M+1 cells and holds exactly one zero. It rotates one cell toward higher indices only on a clock in which the row ring leaves its last active cell.
- R5: A phase ends on the clock where the row ring leaves its last active cell while the column zero sits in cell M. The phase counter then goes from phase one (code 01) to phase two (code 10) to phase three (code 11). The next phase starts with both rings reloaded to their starting cell.
- R6: The select lines follow the phase. Phase one gives sel_true_n=0, sel_comp_n=1, sel_or_n=1. Phase two gives 1,0,1. Phase three, and the done state, give 1,1,0. Each line is active only while test_init is high.
- R7: In phase two the row ring walks a zero. It is loaded with cell 0 at 0 and all other cells at 1, and it rotates over cells 0..L.
- R8: In phase three the row ring walks a zero over cells 0..N only. Cells above N hold 1.
- R9: After the last wrap of phase three, done rises on that clock. The row and column patterns keep the last phase-three state and do not change until reset.
- R10: With test_init low during a test, the rings and the phase counter hold their state and all select lines return to the normal-mode values of R1. Raising test_init again resumes the sequence at the next position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, asynchronous, active low |
| test_init | input | 1 | Test-initialize: starts the test and keeps it running while high |
| row_pat | output | max(L,N)+1 | Row ring cells: bit lines in phases one and two, OR-plane rows in phase three |
| col_pat | output | M+1 | Column ring cells: product-term select, active low |
| sel_true_n | output | 1 | Active-low select for the true bit lines |
| sel_comp_n | output | 1 | Active-low select for the complemented bit lines |
| sel_or_n | output | 1 | Active-low select for the OR-plane rows |
| done | output | 1 | The test sequence has completed |

## Verification
The bench goes through every position of all three phases, using L different from N so that the phase-three tap change is exercised. A design that kept the L+1 tap in phase three would show the marker in the wrong cell. A design that reloaded the wrong polarity at a phase boundary would show a walking one where a zero belongs. The bench checks the clocks just after each phase boundary and just after the final wrap. A column ring that stepped on every clock, or a done flag that let the rings run on, produces a mismatch there. The bench also pauses test_init in the middle of the test: a design that kept stepping or restarted would land on the wrong position when the pin returns.

// File: rtl/pla_seq_pkg.sv
package pla_seq_pkg;
  // Phase code: bit 1 drives the true-line control, bit 0 the complement-line control
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_TRUE = 2'b01,
    PH_COMP = 2'b10,
    PH_OR   = 2'b11
  } phase_t;
endpackage

// File: rtl/pla_rst_sync.sv
module pla_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pla_row_ring.sv
module pla_row_ring #(
  parameter int RW    = 5,
  parameter int LEN_A = 5,
  parameter int LEN_B = 4
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          step,
  input  logic          load,
  input  logic          bg_run,
  input  logic          bg_load,
  input  logic          use_b,
  output logic [RW-1:0] pat,
  output logic          wrap
);
  logic [RW-1:0] pat_q, pat_d, rot_a, rot_sel;
  logic          tap;
  logic          en;

  // rotation over the first LEN_A cells, upper cells held
  always_comb begin
    rot_a    = pat_q;
    rot_a[0] = pat_q[LEN_A-1];
    for (int i = 1; i < LEN_A; i++) rot_a[i] = pat_q[i-1];
  end

  generate
    if (LEN_A == LEN_B) begin : g_single_tap
      assign rot_sel = rot_a;
      assign tap     = pat_q[LEN_A-1];
    end else begin : g_dual_tap
      logic [RW-1:0] rot_b;
      always_comb begin
        rot_b    = pat_q;
        rot_b[0] = pat_q[LEN_B-1];
        for (int i = 1; i < LEN_B; i++) rot_b[i] = pat_q[i-1];
      end
      assign rot_sel = use_b ? rot_b : rot_a;
      assign tap     = use_b ? pat_q[LEN_B-1] : pat_q[LEN_A-1];
    end
  endgenerate

  // marker sits in the last active cell
  assign wrap = (tap != bg_run);
  assign en   = load | step;

  always_comb begin
    if (load) pat_d = {{(RW-1){bg_load}}, ~bg_load};
    else      pat_d = rot_sel;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  pat_q <= '0;
    else if (en)  pat_q <= pat_d;
  end

  assign pat = pat_q;
endmodule

// File: rtl/pla_col_ring.sv
module pla_col_ring #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          step,
  input  logic          load,
  output logic [CW-1:0] pat,
  output logic          at_last
);
  logic [CW-1:0] pat_q, pat_d;
  logic          en;

  assign en = load | step;

  always_comb begin
    if (load) pat_d = {{(CW-1){1'b1}}, 1'b0};
    else      pat_d = {pat_q[CW-2:0], pat_q[CW-1]};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pat_q <= '0;
    else if (en) pat_q <= pat_d;
  end

  assign pat     = pat_q;
  assign at_last = ~pat_q[CW-1];
endmodule

// File: rtl/pla_phase_ctrl.sv
module pla_phase_ctrl
  import pla_seq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       test_init,
  input  logic       row_wrap,
  input  logic       col_last,
  output logic [1:0] phase,
  output logic       done,
  output logic       row_step,
  output logic       col_step,
  output logic       ring_load,
  output logic       bg_run,
  output logic       bg_load,
  output logic       use_or_tap,
  output logic       sel_true_n,
  output logic       sel_comp_n,
  output logic       sel_or_n
);
  phase_t phase_q, phase_d;
  logic   done_q, done_d;
  logic   idle, start, run, adv_col, fin, en;

  assign idle    = (phase_q == PH_IDLE) && !done_q;
  assign start   = test_init && idle;
  assign run     = test_init && !done_q && (phase_q != PH_IDLE);
  assign adv_col = run && row_wrap;
  assign fin     = adv_col && col_last;
  assign en      = start | fin;

  always_comb begin
    phase_d = phase_q;
    done_d  = done_q;
    if (start) begin
      phase_d = PH_TRUE;
    end else if (fin) begin
      if (phase_q == PH_OR) done_d = 1'b1;
      else                  phase_d = phase_t'(phase_q + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else if (en) begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign ring_load  = start | (fin && (phase_q != PH_OR));
  assign row_step   = run && !fin;
  assign col_step   = adv_col && !fin;
  assign bg_run     = phase_q[1];
  assign bg_load    = phase_d[1];
  assign use_or_tap = (phase_q == PH_OR);

  assign sel_true_n = phase_q[1] & test_init;
  assign sel_comp_n = phase_q[0] & test_init;
  assign sel_or_n   = ~(test_init & phase_q[1] & phase_q[0]);

  assign phase = phase_q;
  assign done  = done_q;
endmodule

// File: rtl/pla_test_seq.sv
module pla_test_seq #(
  parameter int L = 4,
  parameter int M = 5,
  parameter int N = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         test_init,
  output logic [((L > N) ? L : N):0]   row_pat,
  output logic [M:0]                   col_pat,
  output logic                         sel_true_n,
  output logic                         sel_comp_n,
  output logic                         sel_or_n,
  output logic                         done
);
  localparam int RW = ((L > N) ? L : N) + 1;
  localparam int CW = M + 1;

  logic       rst_sync_n;
  logic       row_wrap, col_last;
  logic [1:0] phase;
  logic       row_step, col_step, ring_load;
  logic       bg_run, bg_load, use_or_tap;

  pla_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pla_phase_ctrl u_ctrl (
    .clk        (clk),
    .arst_n     (rst_sync_n),
    .test_init  (test_init),
    .row_wrap   (row_wrap),
    .col_last   (col_last),
    .phase      (phase),
    .done       (done),
    .row_step   (row_step),
    .col_step   (col_step),
    .ring_load  (ring_load),
    .bg_run     (bg_run),
    .bg_load    (bg_load),
    .use_or_tap (use_or_tap),
    .sel_true_n (sel_true_n),
    .sel_comp_n (sel_comp_n),
    .sel_or_n   (sel_or_n)
  );

  pla_row_ring #(.RW(RW), .LEN_A(L + 1), .LEN_B(N + 1)) u_row (
    .clk     (clk),
    .arst_n  (rst_sync_n),
    .step    (row_step),
    .load    (ring_load),
    .bg_run  (bg_run),
    .bg_load (bg_load),
    .use_b   (use_or_tap),
    .pat     (row_pat),
    .wrap    (row_wrap)
  );

  pla_col_ring #(.CW(CW)) u_col (
    .clk     (clk),
    .arst_n  (rst_sync_n),
    .step    (col_step),
    .load    (ring_load),
    .pat     (col_pat),
    .at_last (col_last)
  );
endmodule

// File: rtl/pla_test_seq_chk.sv
module pla_test_seq_chk #(
  parameter int L = 4,
  parameter int M = 5,
  parameter int N = 3
) (
  input logic                       clk,
  input logic                       rst_ok_n,
  input logic                       test_init,
  input logic [((L > N) ? L : N):0] row_pat,
  input logic [M:0]                 col_pat,
  input logic                       sel_true_n,
  input logic                       sel_comp_n,
  input logic                       sel_or_n,
  input logic                       done,
  input logic [1:0]                 phase,
  input logic                       row_wrap
);
  AST_ROW_ONE_HOT_TRUE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (phase == 2'b01) |-> ($countones(row_pat[L:0]) == 1)); // R3
  AST_ROW_ONE_COLD_COMP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (phase == 2'b10) |-> ($countones(row_pat[L:0]) == L)); // R7
  AST_ROW_ONE_COLD_OR: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (phase == 2'b11) |-> ($countones(row_pat[N:0]) == N)); // R8
  AST_COL_ONE_COLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (phase != 2'b00) |-> ($countones(col_pat) == M)); // R4
  AST_COL_HOLD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (test_init && (phase != 2'b00) && !done && !row_wrap) |=> $stable(col_pat)); // R4
  AST_PHASE_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (phase != $past(phase)) |-> (phase == $past(phase) + 2'd1)); // R5
  AST_SEL_OR_EXCL: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !sel_or_n |-> (sel_true_n && sel_comp_n)); // R6
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done |=> (done && $stable(row_pat) && $stable(col_pat))); // R9
  AST_INIT_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !test_init |=> ($stable(row_pat) && $stable(col_pat) && $stable(phase))); // R10
endmodule

bind pla_test_seq pla_test_seq_chk #(.L(L), .M(M), .N(N)) u_chk (
  .clk        (clk),
  .rst_ok_n   (rst_sync_n),
  .test_init  (test_init),
  .row_pat    (row_pat),
  .col_pat    (col_pat),
  .sel_true_n (sel_true_n),
  .sel_comp_n (sel_comp_n),
  .sel_or_n   (sel_or_n),
  .done       (done),
  .phase      (phase),
  .row_wrap   (row_wrap)
);

// File: tb/test_pla_test_seq.sv
`timescale 1ns/1ps
module test_pla_test_seq;
  localparam int L  = 4;
  localparam int M  = 5;
  localparam int N  = 3;
  localparam int RW = ((L > N) ? L : N) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          test_init;
  logic [RW-1:0] row_pat;
  logic [M:0]    col_pat;
  logic          sel_true_n, sel_comp_n, sel_or_n, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pla_test_seq #(.L(L), .M(M), .N(N)) i_pla_test_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_init  (test_init),
    .row_pat    (row_pat),
    .col_pat    (col_pat),
    .sel_true_n (sel_true_n),
    .sel_comp_n (sel_comp_n),
    .sel_or_n   (sel_or_n),
    .done       (done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ring_len(input int p);
    return (p == 3) ? N + 1 : L + 1;
  endfunction

  function automatic logic [RW-1:0] exp_row(input int p, input int k);
    logic [RW-1:0] r;
    logic          bg;
    bg = (p != 1);
    r  = {RW{bg}};
    r[k % ring_len(p)] = ~bg;
    return r;
  endfunction

  function automatic logic [M:0] exp_col(input int p, input int k);
    logic [M:0] c;
    c = '1;
    c[k / ring_len(p)] = 1'b0;
    return c;
  endfunction

  task automatic check_state(input int p, input int k, input string rtag, input bit ti_on);
    chk({rtag, " row"}, row_pat, exp_row(p, k));
    chk("R4 col", col_pat, exp_col(p, k));
    chk("R6 sel_true_n", sel_true_n, ti_on ? (p != 1) : 1'b0);
    chk("R6 sel_comp_n", sel_comp_n, ti_on ? (p != 2) : 1'b0);
    chk("R6 sel_or_n",   sel_or_n,   ti_on ? (p != 3) : 1'b1);
  endtask

  task automatic reset_block();
    rst_n     = 1'b0;
    test_init = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int kl;
    string rtag;
    reset_block();
    // R1: reset state, idle with test_init low
    for (int i = 0; i < 3; i++) begin
      chk("R1 row", row_pat, '0);
      chk("R1 col", col_pat, '0);
      chk("R1 done", done, 1'b0);
      chk("R1 sel", {sel_true_n, sel_comp_n, sel_or_n}, 3'b001);
      @(negedge clk);
    end
    test_init = 1'b1;
    @(negedge clk);
    chk("R2 row start", row_pat, exp_row(1, 0));
    chk("R2 col start", col_pat, exp_col(1, 0));
    // full sweep over all three phases
    for (int p = 1; p <= 3; p++) begin
      kl = (M + 1) * ring_len(p);
      for (int k = 0; k < kl; k++) begin
        if (k == 0 && p > 1)  rtag = "R5";
        else if (p == 1)      rtag = "R3";
        else if (p == 2)      rtag = "R7";
        else                  rtag = "R8";
        check_state(p, k, rtag, 1'b1);
        chk("R9 done low", done, 1'b0);
        @(negedge clk);
      end
    end
    // R9: done and frozen
    for (int i = 0; i < 4; i++) begin
      chk("R9 done", done, 1'b1);
      chk("R9 row frozen", row_pat, exp_row(3, (M + 1) * (N + 1) - 1));
      chk("R9 col frozen", col_pat, exp_col(3, (M + 1) * (N + 1) - 1));
      chk("R9 sel_or_n", sel_or_n, 1'b0);
      @(negedge clk);
    end
    // R10: pause mid-test
    reset_block();
    chk("R1 row after second reset", row_pat, '0);
    chk("R1 done after second reset", done, 1'b0);
    test_init = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 7; i++) @(negedge clk);
    check_state(1, 7, "R3", 1'b1);
    test_init = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_state(1, 7, "R10", 1'b0);
    end
    test_init = 1'b1;
    @(negedge clk);
    check_state(1, 8, "R10", 1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule